// File: doc/BRIEF.md
# GPIO Pin Function and Output Register File

This block is a memory-mapped register file for a bank of general-purpose pins, up to 58 of them, split over two 32-bit banks. Every pin owns a 3-bit function field. The field selects plain input, plain output, or one of six alternate functions. The function code is driven out so that an external multiplexer can route the pin to a peripheral. The block drives the output enable only when the pin is configured as a plain output.

The output latches change only through two write-one registers, one that sets bits and one that clears them. Software can therefore drive one pin without a read-modify-write sequence, and it cannot disturb a neighbouring pin. Each pin input passes through a two-flop synchronizer before it reaches a level register that software can read.

The bus side is a single-cycle write port and a read port whose data is registered. The word index is taken from address bits [7:2].

Top module: `gpio_regfile`

## Requirements
- R1: After reset, every function field is 000 (plain input), every output latch is 0, and every output enable is 0.
- R2: The function field of pin p sits in the word at byte offset 4×(p/10), starting at bit 3×(p%10). Writing the word updates the fields of its ten pins, and reading the word returns them. Bits 31:30 of each function word read as 0.
- R3: Function code 000 means plain input and 001 means plain output. Codes 100, 101, 110 and 111 are alternates 0 to 3, and codes 011 and 010 are alternates 4 and 5. `pin_func` shows every pin's field. `pin_oe` of a pin is 1 exactly when its code is 001.
- R4: A write to offset 0x1C (pins 0–31) or 0x20 (pins 32 and up, bit p−32) sets the output latch of every pin whose bit is 1. Pins whose bit is 0 keep their latch value.
- R5: A write to offset 0x28 (pins 0–31) or 0x2C (pins 32 and up) clears the output latch of every pin whose bit is 1. Pins whose bit is 0 keep their latch value.
- R6: Reads of the set words and the clear words return 0.
- R7: Offset 0x34 (pins 0–31) and offset 0x38 (pins 32 and up) return the pin levels after a two-flop synchronizer. A change on `pin_in` is seen by a read whose data is captured on the third rising edge after the change, and not by a read captured earlier.
- R8: Field bits and level bits that belong to pin numbers at or beyond NUM_PINS read as 0. Writes to those bits have no effect.
- R9: Read data appears on `bus_rdata` one cycle after `bus_rd_en`. Unmapped word offsets read as 0. Writes to unmapped offsets and to the level words change no latch and no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; data is valid in the next cycle |
| bus_addr | input | ADDR_W | Byte address; bits [7:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enable, high for plain-output pins |
| pin_func | output | 3×NUM_PINS | Function code of each pin, pin p at bits [3p+2:3p] |

## Verification
The bench writes a set word that has only a few ones and checks that latches set earlier survive. A design that did a read-modify-write, or that loaded the word straight into the latches, would wipe those latches. It writes all ones into the last function word and into the upper set word. A design with a wrong field mapping, or one that failed to mask pins beyond 57, would either show phantom fields on read or fail to set pin 57. It sweeps all eight codes on one pin and checks the output enable each time, which would expose a decode that treats alternate codes as outputs. Finally, it reads the level word on three edges in a row after a pin change. A synchronizer with one stage too few or one too many would show the new level on the wrong edge.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

  typedef enum logic [2:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } pin_fn_e;

  localparam int FIELD_W      = 3;
  localparam int PINS_PER_SEL = 10;
  localparam int BANK_W       = 32;
  localparam int SEL_SPAN     = FIELD_W * PINS_PER_SEL;

  // word indices (byte offset / 4)
  localparam int SET_WORD0 = 7;
  localparam int CLR_WORD0 = 10;
  localparam int LVL_WORD0 = 13;

  function automatic int sel_word(input int p);
    return p / PINS_PER_SEL;
  endfunction

  function automatic int sel_lsb(input int p);
    return FIELD_W * (p % PINS_PER_SEL);
  endfunction

  function automatic int bank_of(input int p);
    return p / BANK_W;
  endfunction

  function automatic int bit_of(input int p);
    return p % BANK_W;
  endfunction

endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_rf_pkg::*;
#(
  parameter int NUM_PINS = 58,
  parameter int IDX_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            word_idx,
  input  logic [31:0]                 wdata,
  output logic [FIELD_W*NUM_PINS-1:0] func,
  output logic                        fsel_wr_any
);
  localparam int SEL_WORDS = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;

  assign fsel_wr_any = wr_en && (int'(word_idx) < SEL_WORDS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int W = sel_word(p);
    localparam int L = sel_lsb(p);
    logic hit;
    assign hit = wr_en && (int'(word_idx) == W);
    always_ff @(posedge clk) begin
      if (!rst_n)   func[FIELD_W*p +: FIELD_W] <= FN_INPUT;
      else if (hit) func[FIELD_W*p +: FIELD_W] <= wdata[L +: FIELD_W];
    end
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_rf_pkg::*;
#(
  parameter int NUM_PINS = 58,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    word_idx,
  input  logic [31:0]         wdata,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                set_wr_any,
  output logic                clr_wr_any
);
  localparam int BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  assign set_wr_any = wr_en && (int'(word_idx) >= SET_WORD0) &&
                      (int'(word_idx) < SET_WORD0 + BANKS);
  assign clr_wr_any = wr_en && (int'(word_idx) >= CLR_WORD0) &&
                      (int'(word_idx) < CLR_WORD0 + BANKS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = bank_of(p);
    localparam int K = bit_of(p);
    logic do_set, do_clr;
    assign do_set = wr_en && (int'(word_idx) == SET_WORD0 + B) && wdata[K];
    assign do_clr = wr_en && (int'(word_idx) == CLR_WORD0 + B) && wdata[K];
    always_ff @(posedge clk) begin
      if (!rst_n)      pin_out[p] <= 1'b0;
      else if (do_set) pin_out[p] <= 1'b1;
      else if (do_clr) pin_out[p] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 58
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] level
);
  logic [NUM_PINS-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      level  <= '0;
    end else begin
      stage1 <= pin_in;
      level  <= stage1;
    end
  end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_rf_pkg::*;
#(
  parameter int NUM_PINS = 58,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr_en,
  input  logic                        bus_rd_en,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS-1:0]         pin_oe,
  output logic [FIELD_W*NUM_PINS-1:0] pin_func
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int SEL_WORDS = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;
  localparam int BANKS     = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int FPAD_W    = SEL_WORDS * SEL_SPAN;
  localparam int LPAD_W    = BANKS * BANK_W;

  logic [IDX_W-1:0]    word_idx;
  logic [NUM_PINS-1:0] level;
  logic [FPAD_W-1:0]   func_pad;
  logic [LPAD_W-1:0]   lvl_pad;
  logic [31:0]         rd_word;
  logic                fsel_wr_any, set_wr_any, clr_wr_any;

  assign word_idx = bus_addr[ADDR_W-1:2];

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word_idx(word_idx),
    .wdata(bus_wdata), .func(pin_func), .fsel_wr_any(fsel_wr_any)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word_idx(word_idx),
    .wdata(bus_wdata), .pin_out(pin_out),
    .set_wr_any(set_wr_any), .clr_wr_any(clr_wr_any)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level(level)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe[p] = (pin_func[FIELD_W*p +: FIELD_W] == FN_OUTPUT);
  end

  // zero-extend so pins past NUM_PINS read as zero
  assign func_pad = FPAD_W'(pin_func);
  assign lvl_pad  = LPAD_W'(level);

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < SEL_WORDS; w++)
      if (int'(word_idx) == w) rd_word[SEL_SPAN-1:0] = func_pad[w*SEL_SPAN +: SEL_SPAN];
    for (int b = 0; b < BANKS; b++)
      if (int'(word_idx) == LVL_WORD0 + b) rd_word = lvl_pad[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_word;
  end

endmodule

// File: rtl/gpio_rf_checker.sv
module gpio_rf_checker
  import gpio_rf_pkg::*;
#(
  parameter int NUM_PINS = 58,
  parameter int ADDR_W   = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_rd_en,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_PINS-1:0]         pin_out,
  input logic [NUM_PINS-1:0]         pin_oe,
  input logic [FIELD_W*NUM_PINS-1:0] pin_func,
  input logic                        fsel_wr_any,
  input logic                        set_wr_any,
  input logic                        clr_wr_any
);
  localparam int BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  logic [ADDR_W-3:0] idx;
  logic              rd_setclr;
  assign idx = bus_addr[ADDR_W-1:2];
  assign rd_setclr = bus_rd_en &&
    (((int'(idx) >= SET_WORD0) && (int'(idx) < SET_WORD0 + BANKS)) ||
     ((int'(idx) >= CLR_WORD0) && (int'(idx) < CLR_WORD0 + BANKS)));

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pin_out == '0 && pin_func == '0 && pin_oe == '0)); // R1
  AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel_wr_any |=> $stable(pin_func)); // R2
  AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr_any |=> ((pin_out & $past(pin_out)) == $past(pin_out))); // R4
  AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_any |=> ((pin_out | $past(pin_out)) == $past(pin_out))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr_any || clr_wr_any) |=> $stable(pin_out)); // R9
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_setclr |=> (bus_rdata == '0)); // R6

endmodule

bind gpio_regfile gpio_rf_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func),
  .fsel_wr_any(fsel_wr_any), .set_wr_any(set_wr_any), .clr_wr_any(clr_wr_any)
);

// File: tb/sim_gpio_regfile.sv
module sim_gpio_regfile;
  localparam int NP = 58;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [3*NP-1:0] pin_func;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_regfile #(.NUM_PINS(NP), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [2:0] fn_of(input int p);
    return pin_func[3*p +: 3];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_out", 64'(pin_out), 64'd0);
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 pin_func low", 64'(pin_func[63:0]), 64'd0);
    rd(8'h14, d);
    chk("R1 word5 readback", 64'(d), 64'd0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    // pin 1 -> output (bits 5:3), pin 9 -> alt0 code 100 (bits 29:27)
    wr(8'h00, (32'd1 << 3) | (32'd4 << 27) | 32'hC000_0000);
    rd(8'h00, d);
    chk("R2 word0 readback, top bits zero", 64'(d), 64'(32'h2000_0008));
    chk("R2 pin1 field", 64'(fn_of(1)), 64'd1);
    chk("R2 pin9 field", 64'(fn_of(9)), 64'd4);
    chk("R3 pin1 oe", 64'(pin_oe[1]), 64'd1);
    chk("R3 pin9 oe (alt)", 64'(pin_oe[9]), 64'd0);
    // pin 34 = word 3, lsb 12
    wr(8'h0C, 32'd6 << 12);
    chk("R2 pin34 field", 64'(fn_of(34)), 64'd6);
    chk("R2 pin33 untouched", 64'(fn_of(33)), 64'd0);
    // word5 all ones: only pins 50..57 exist
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d);
    chk("R8 word5 beyond pin 57 reads zero", 64'(d), 64'(32'h00FF_FFFF));
    chk("R2 pin57 field", 64'(fn_of(57)), 64'd7);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      wr(8'h08, 32'(c) << 9);  // pin 23
      chk($sformatf("R3 pin23 func code %0d", c), 64'(fn_of(23)), 64'(c));
      chk($sformatf("R3 pin23 oe code %0d", c), 64'(pin_oe[23]), 64'(c == 1));
    end
    wr(8'h08, 32'h0);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(8'h1C, 32'h0000_00A5);
    chk("R4 set low bank", 64'(pin_out), 64'h0A5);
    wr(8'h1C, 32'h0000_0002);
    chk("R4 zero bits keep latches", 64'(pin_out), 64'h0A7);
    wr(8'h28, 32'h0000_0005);
    chk("R5 clear low bank", 64'(pin_out), 64'h0A2);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R4 set upper bank to pin 57", 64'(pin_out), {6'd0, 26'h3FF_FFFF, 32'h0000_00A2});
    wr(8'h2C, 32'h0200_0001);
    chk("R5 clear pins 32 and 57", 64'(pin_out), {6'd0, 26'h1FF_FFFE, 32'h0000_00A2});
    rd(8'h1C, d); chk("R6 set word reads zero", 64'(d), 64'd0);
    rd(8'h2C, d); chk("R6 clear word reads zero", 64'(d), 64'd0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    logic [NP-1:0] pat = {26'h3AB_CDEF, 32'h1234_5678};
    pin_in = '0;
    repeat (3) @(negedge clk);
    pin_in = pat;
    rd(8'h34, d); chk("R7 edge1 still old", 64'(d), 64'd0);
    rd(8'h34, d); chk("R7 edge2 still old", 64'(d), 64'd0);
    rd(8'h34, d); chk("R7 edge3 new level", 64'(d), 64'(32'h1234_5678));
    rd(8'h38, d); chk("R7 upper level word", 64'(d), 64'(32'h03AB_CDEF));
    pin_in = '1;
    repeat (3) @(negedge clk);
    rd(8'h38, d); chk("R8 level bits past pin 57 zero", 64'(d), 64'(32'h03FF_FFFF));
  endtask

  task automatic t_misc;
    logic [31:0] d;
    logic [NP-1:0] o;
    logic [3*NP-1:0] f;
    o = pin_out; f = pin_func;
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R9 writes to level/unmapped keep latches", 64'(pin_out), 64'(o));
    chk("R9 writes to level/unmapped keep fields", 64'(pin_func[63:0]), 64'(f[63:0]));
    rd(8'h40, d); chk("R9 unmapped 0x40 reads zero", 64'(d), 64'd0);
    rd(8'h18, d); chk("R9 unmapped 0x18 reads zero", 64'(d), 64'd0);
    // latency: the rdata just before a read reflects previous read
    bus_rd_en = 1'b1; bus_addr = 8'h00;
    #1 chk("R9 rdata not yet updated", 64'(bus_rdata), 64'd0);
    @(negedge clk); bus_rd_en = 1'b0;
    chk("R9 rdata after one edge", 64'(bus_rdata), 64'(32'h2000_0008));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_codes();
    t_setclr();
    t_level();
    t_misc();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule